// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This block takes a wide vector of GPIO pad inputs and routes a small number of them onto interrupt channels for a downstream interrupt controller. Each channel has its own register fields:

- a pad selector,
- a level/edge mode bit,
- an inversion bit,
- a glitch-filter length.

The selected pad is synchronised, optionally inverted, filtered, and then either passed through as a level or turned into a single-cycle pulse on each rise. Every output is therefore active-high. A sink that only accepts high levels or rising edges can still receive active-low and falling-edge requests. Only one edge direction is sensed per channel.

Software programs the block through a 32-bit register port addressed by word index. Word 0 holds the edge-enable bits (7:0) and the invert bits (23:16). Words 1 and 2 hold four 8-bit selectors each. Word 3 holds eight 4-bit filter lengths. Writing word 0, or the selector word of a channel, restarts that channel's filter count and suppresses its output for one cycle.

Top module: `gpio_irq_mux`

## Requirements
- R1: After synchronous reset, every register word reads zero and all `irq` bits are low.
- R2: A read issued with `rd_en` returns the addressed word on `rdata` one cycle later. The fields are laid out as follows:
  - word 0: edge enable of channel c at bit c, invert of channel c at bit 16+c; bits 15:8 and 31:24 read as zero;
  - word 1: selector of channel c (c = 0..3) at bits (c mod 4)*8 +: 8;
  - word 2: selector of channel c (c = 4..7) at the same bit positions;
  - word 3: filter length of channel c at bits c*4 +: 4.
  
  All of these fields read back exactly as written.
- R3: In level mode with filter length 0, `irq[c]` follows the selected pad. A pad change applied before clock edge 1 is visible after edge 5.
- R4: With the invert bit set in level mode, a low pad drives `irq[c]` high and a high pad drives it low.
- R5: In edge mode, each rise of the filtered signal produces exactly one one-cycle `irq[c]` pulse, 5 edges after the pad rises. A falling pad produces no pulse.
- R6: In edge mode with invert set, a falling pad produces one pulse and a rising pad produces none.
- R7: With filter length k > 0, a change reaches the filter only after the synchronised input has held the new value for 2k consecutive cycles, giving a latency of 4+2k edges. Shorter glitches never reach `irq`.
- R8: A write to word 0, or to a channel's selector word, clears that channel's filter count and forces its `irq` low in the following cycle.
- R9: `rdata` keeps its value in every cycle without `rd_en`.
- R10: Several channels may select the same pad, and each applies its own invert bit independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 2 | Register word index (0..3) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pads | input | 256 | Asynchronous GPIO pad inputs |
| irq | output | 8 | Active-high interrupt channel outputs |

## Verification
The hardest condition to reach from the ports is a register write that lands while a channel's filter is part-way through counting a change. The write must push the output edge later by exactly the number of cycles already counted. The stimulus sets a filter length of 3, raises the pad, and rewrites the unchanged selector word on a chosen edge. It then checks that the output is still low on the edge where it would have risen without the write, and high three edges later. Glitches one cycle shorter than the filter window are driven as well, together with randomised selector, invert and pad patterns that include several channels sharing one pad.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int SEL_SLOT  = 8;               // bits reserved per selector
  localparam int PER_WORD  = DATA_W / SEL_SLOT;
  localparam int INV_BASE  = 16;              // invert bits start here in word 0
  localparam int WORD_MODE = 0;
  localparam int WORD_SEL0 = 1;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int FLT_W  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [IDX_W-1:0]              reg_idx,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_CH-1:0]             edge_mode,
  output logic [NUM_CH-1:0]             invert,
  output logic [NUM_CH-1:0][SEL_W-1:0]  sel,
  output logic [NUM_CH-1:0][FLT_W-1:0]  flt,
  output logic [NUM_CH-1:0]             cfg_chg
);
  localparam int SEL_WORDS = (NUM_CH + PER_WORD - 1) / PER_WORD;
  localparam int FLT_WORD  = WORD_SEL0 + SEL_WORDS;

  logic [DATA_W-1:0] rd_val;

  // configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_mode <= '0;
      invert    <= '0;
      sel       <= '0;
      flt       <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (reg_idx == IDX_W'(WORD_MODE)) begin
          edge_mode[c] <= wdata[c];
          invert[c]    <= wdata[INV_BASE + c];
        end
        if (reg_idx == IDX_W'(WORD_SEL0 + c / PER_WORD))
          sel[c] <= wdata[(c % PER_WORD) * SEL_SLOT +: SEL_W];
        if (reg_idx == IDX_W'(FLT_WORD))
          flt[c] <= wdata[c * FLT_W +: FLT_W];
      end
    end
  end

  // per-channel change strobe: mode word or the word holding its selector
  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      cfg_chg[c] = wr_en && (reg_idx == IDX_W'(WORD_MODE) ||
                             reg_idx == IDX_W'(WORD_SEL0 + c / PER_WORD));
  end

  // read mux
  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_idx == IDX_W'(WORD_MODE)) begin
        rd_val[c]            = edge_mode[c];
        rd_val[INV_BASE + c] = invert[c];
      end
      if (reg_idx == IDX_W'(WORD_SEL0 + c / PER_WORD))
        rd_val[(c % PER_WORD) * SEL_SLOT +: SEL_W] = sel[c];
      if (reg_idx == IDX_W'(FLT_WORD))
        rd_val[c * FLT_W +: FLT_W] = flt[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/gpio_irq_channel.sv
module gpio_irq_channel #(
  parameter int NUM_PADS = 256,
  parameter int SEL_W    = 8,
  parameter int FLT_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pads_s,
  input  logic [SEL_W-1:0]    sel,
  input  logic                invert,
  input  logic                edge_mode,
  input  logic [FLT_W-1:0]    flt,
  input  logic                cfg_chg,
  output logic                irq
);
  localparam int CNT_W = FLT_W + 1;

  logic             sel_q;
  logic             filt;
  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = {flt, 1'b0};   // hold window is twice the setting

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      filt  <= 1'b0;
      prev  <= 1'b0;
      cnt   <= '0;
      irq   <= 1'b0;
    end else begin
      sel_q <= pads_s[sel] ^ invert;
      prev  <= filt;

      if (flt == '0) begin
        filt <= sel_q;
        cnt  <= '0;
      end else if (cfg_chg || sel_q == filt) begin
        cnt <= '0;
      end else if (cnt + 1'b1 == limit) begin
        filt <= sel_q;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end

      if (cfg_chg)        irq <= 1'b0;
      else if (edge_mode) irq <= filt & ~prev;
      else                irq <= filt;
    end
  end
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 256,
  parameter int NUM_CH   = 8,
  parameter int FLT_W    = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PADS-1:0] pads,
  output logic [NUM_CH-1:0]   irq
);
  localparam int SEL_W = $clog2(NUM_PADS);

  logic [NUM_PADS-1:0]            pads_s;
  logic [NUM_CH-1:0]              cfg_edge;
  logic [NUM_CH-1:0]              cfg_inv;
  logic [NUM_CH-1:0][SEL_W-1:0]   cfg_sel;
  logic [NUM_CH-1:0][FLT_W-1:0]   cfg_flt;
  logic [NUM_CH-1:0]              cfg_chg;

  gpio_irq_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pads),
    .q   (pads_s)
  );

  gpio_irq_regs #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .FLT_W  (FLT_W),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .reg_idx   (reg_idx),
    .wdata     (wdata),
    .rdata     (rdata),
    .edge_mode (cfg_edge),
    .invert    (cfg_inv),
    .sel       (cfg_sel),
    .flt       (cfg_flt),
    .cfg_chg   (cfg_chg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gpio_irq_channel #(
      .NUM_PADS (NUM_PADS),
      .SEL_W    (SEL_W),
      .FLT_W    (FLT_W)
    ) u_ch (
      .clk       (clk),
      .rst       (rst),
      .pads_s    (pads_s),
      .sel       (cfg_sel[c]),
      .invert    (cfg_inv[c]),
      .edge_mode (cfg_edge[c]),
      .flt       (cfg_flt[c]),
      .cfg_chg   (cfg_chg[c]),
      .irq       (irq[c])
    );
  end
endmodule

// File: rtl/gpio_irq_mux_chk.sv
module gpio_irq_mux_chk #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [31:0]       rdata,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] edge_mode
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (irq == '0 && rdata == '0));

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_idx == '0) |=> (rdata[15:8] == 8'h00 && rdata[31:24] == 8'h00));

  assert_cfg_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == '0) |=> irq == '0);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pulse
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      (irq[c] && edge_mode[c] && !wr_en) |=> !irq[c]);
  end
endmodule

bind gpio_irq_mux gpio_irq_mux_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .reg_idx   (reg_idx),
  .rdata     (rdata),
  .irq       (irq),
  .edge_mode (cfg_edge)
);

// File: tb/gpio_irq_mux_test.sv
`timescale 1ns/1ps
module gpio_irq_mux_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   reg_idx = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [255:0] pads = '0;
  logic [7:0]   irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  gpio_irq_mux uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rdata), .pads(pads), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    wr_en = 1'b1; reg_idx = idx; wdata = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    rd_en = 1'b1; reg_idx = idx;
    tick(1);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [7:0] model_irq(input logic [255:0] p,
                                            input logic [7:0] s [8],
                                            input logic [7:0] inv);
    logic [7:0] r;
    for (int c = 0; c < 8; c++) r[c] = p[s[c]] ^ inv[c];
    return r;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    int pulses, first;
    logic [7:0] rs [8];
    logic [7:0] inv;

    void'($urandom(32'd20240611));
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1: reset state
    for (int w = 0; w < 4; w++) begin
      rd(2'(w), d);
      chk("R1 reset word", d, 32'h0);
    end
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);

    // R2: readback and unused bits
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 word0 mask", d, 32'h00FF_00FF);
    wr(1, 32'hA5C3_1E7F); rd(1, d); chk("R2 word1", d, 32'hA5C3_1E7F);
    wr(2, 32'h0123_89EF); rd(2, d); chk("R2 word2", d, 32'h0123_89EF);
    wr(3, 32'hDEAD_BEEF); rd(3, d); chk("R2 word3", d, 32'hDEAD_BEEF);
    // R9: rdata holds without rd_en
    held = d;
    wr(1, 32'h1111_2222);
    tick(3);
    chk("R9 rdata hold", rdata, held);

    // clean config: ch2 selects pad 77, all else pad 0, level, no filter
    wr(0, 0); wr(1, 32'h004D_0000); wr(2, 0); wr(3, 0);
    tick(10);

    // R3: level latency
    pads[77] = 1'b1;
    tick(4); chk("R3 not yet at edge 4", {24'h0, irq}, 32'h0);
    tick(1); chk("R3 high at edge 5", {24'h0, irq}, 32'h4);
    pads[77] = 1'b0;
    tick(5); chk("R3 follows low", {24'h0, irq}, 32'h0);

    // R4: inversion in level mode
    wr(0, 32'h0004_0000);
    tick(8); chk("R4 low pad gives high", {24'h0, irq}, 32'h4);
    pads[77] = 1'b1;
    tick(8); chk("R4 high pad gives low", {24'h0, irq}, 32'h0);
    pads[77] = 1'b0;

    // R5: edge mode, rising pad
    wr(0, 32'h0000_0004);
    tick(10);
    pads[77] = 1'b1;
    pulses = 0; first = 0;
    for (int i = 1; i <= 12; i++) begin
      tick(1);
      if (irq[2]) begin pulses++; if (first == 0) first = i; end
    end
    chk("R5 one pulse on rise", pulses, 1);
    chk("R5 pulse at edge 5", first, 5);
    pads[77] = 1'b0;
    pulses = 0;
    for (int i = 1; i <= 12; i++) begin tick(1); if (irq[2]) pulses++; end
    chk("R5 no pulse on fall", pulses, 0);

    // R6: edge mode with inversion
    wr(0, 32'h0004_0004);
    tick(10);
    pads[77] = 1'b1;
    pulses = 0;
    for (int i = 1; i <= 12; i++) begin tick(1); if (irq[2]) pulses++; end
    chk("R6 no pulse on rise", pulses, 0);
    pads[77] = 1'b0;
    pulses = 0; first = 0;
    for (int i = 1; i <= 12; i++) begin
      tick(1);
      if (irq[2]) begin pulses++; if (first == 0) first = i; end
    end
    chk("R6 one pulse on fall", pulses, 1);
    chk("R6 pulse at edge 5", first, 5);

    // R7: filter k=2 on ch2, level mode
    wr(0, 0); wr(3, 32'h0000_0200);
    tick(10);
    pads[77] = 1'b1; tick(3); pads[77] = 1'b0;
    pulses = 0;
    for (int i = 1; i <= 15; i++) begin tick(1); if (irq[2]) pulses++; end
    chk("R7 short glitch ignored", pulses, 0);
    pads[77] = 1'b1;
    tick(7); chk("R7 low at edge 7", {31'h0, irq[2]}, 32'h0);
    tick(1); chk("R7 high at edge 8", {31'h0, irq[2]}, 32'h1);
    pads[77] = 1'b0;
    tick(12);

    // R8: write mid-filter restarts count (k=3)
    wr(3, 32'h0000_0300);
    tick(12);
    pads[77] = 1'b1;
    tick(5);
    wr(1, 32'h004D_0000);                 // lands on edge 6
    tick(4); chk("R8 delayed past edge 10", {31'h0, irq[2]}, 32'h0);
    tick(3); chk("R8 high at edge 13", {31'h0, irq[2]}, 32'h1);
    wr(0, 0);
    chk("R8 write forces low", {31'h0, irq[2]}, 32'h0);
    tick(1); chk("R8 returns high", {31'h0, irq[2]}, 32'h1);
    pads[77] = 1'b0;

    // R10: all channels on one pad, half inverted
    wr(3, 0);
    wr(1, 32'hC8C8_C8C8); wr(2, 32'hC8C8_C8C8);
    wr(0, 32'h000F_0000);
    pads[200] = 1'b1;
    tick(8); chk("R10 shared pad", {24'h0, irq}, 32'h0000_00F0);

    // R3/R4 random patterns
    for (int it = 0; it < 24; it++) begin
      for (int c = 0; c < 8; c++) rs[c] = 8'($urandom());
      if (it % 4 == 0) rs[5] = rs[1];
      inv = 8'($urandom());
      pads = {$urandom(), $urandom(), $urandom(), $urandom(),
              $urandom(), $urandom(), $urandom(), $urandom()};
      wr(1, {rs[3], rs[2], rs[1], rs[0]});
      wr(2, {rs[7], rs[6], rs[5], rs[4]});
      wr(0, {8'h0, inv, 16'h0});
      tick(8);
      chk("R3 R4 random routing", {24'h0, irq}, {24'h0, model_irq(pads, rs, inv)});
    end

    finish_run();
  end
endmodule